// File: doc/BRIEF.md
# MDIO Management Slave

This block is the PHY-side end of a two-wire serial management link. It takes its clock from the management clock pin (MDC) and shares one bidirectional data line (MDIO) with a station controller. The pad itself sits outside the block: the block sees the line through a sampled input and drives it through separate output-data and output-enable signals. Incoming bits are sampled on the rising MDC edge. Whatever the slave drives changes on the falling edge, so the line is settled when the station samples it.

Each frame carries these fields in order: a run of ones as preamble, the start pattern `01`, a two-bit opcode, a five-bit PHY address, a five-bit register address, a two-bit turnaround and sixteen data bits. Every field is sent most-significant bit first. A read copies the addressed 16-bit register onto the line. A write stores the data field into that register. The register bank has `NUM_REGS` registers at addresses 0 to `NUM_REGS-1`, and all other addresses are unimplemented. Frames for another PHY address, and frames with an unused opcode, pass by without effect. A new frame may follow the last data bit of the previous one directly, with no idle bit.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A frame is recognised only when a 0 arrives after at least 32 consecutive sampled ones and is followed by a 1. When the preamble is shorter, the frame causes no drive and no register change.
- R2: When a frame's PHY address differs from `phy_addr_i`, `mdio_oe` stays 0 for the whole frame and no register changes.
- R3: In a read frame with a matching address, `mdio_oe` is 0 during the first turnaround bit. During the second turnaround bit `mdio_oe` is 1 and `mdio_o` is 0.
- R4: In a matching read (opcode `10`), the 16 data bits are driven with `mdio_oe` at 1, bit 15 first. Each bit is updated on the falling MDC edge before the rising edge on which the station samples it.
- R5: In a matching write (opcode `01`), the slave never drives during turnaround or data. The 16 data bits, taken bit 15 first, are stored into the addressed implemented register at the last data bit.
- R6: A matching read of an address of `NUM_REGS` or higher returns 16'hFFFF.
- R7: A matching write to an address of `NUM_REGS` or higher leaves every register unchanged.
- R8: Outside the turnaround and data fields of a matching read, `mdio_oe` is 0. This includes idle time, preamble and the header fields.
- R9: A new preamble may start on the bit that follows the last data bit, and that frame is handled normally.
- R10: Opcodes `00` and `11` cause no drive and no register change.
- R11: After reset every register reads 16'h0000 and `mdio_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| phy_addr_i | input | 5 | PHY address this slave answers to (static configuration) |
| mdio_i | input | 1 | Sampled level of the MDIO line |
| mdio_o | output | 1 | Value driven onto MDIO when enabled |
| mdio_oe | output | 1 | Tri-state enable for MDIO, 1 = slave drives |

## Verification
The assertions assume that `phy_addr_i` stays constant while a frame is in progress. They also assume that `mdio_i` reflects the slave's own drive whenever `mdio_oe` is 1, as a real pad with a pull-up would. The bench builds the line the same way: the slave's output wins while it is enabled, otherwise the station's drive, otherwise a pull-up one. It changes the configured address only while in reset and never drives the line while the slave holds it. Short preambles are sent only right after a deliberate 0 bit, so no trailing ones from an earlier frame can make up the missing preamble bits.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef enum logic [2:0] {
    ST_PRE   = 3'd0,
    ST_START = 3'd1,
    ST_OP    = 3'd2,
    ST_PHY   = 3'd3,
    ST_REG   = 3'd4,
    ST_TA    = 3'd5,
    ST_DATA  = 3'd6
  } mdio_st_e;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;

endpackage

// File: rtl/mdio_rst_sync.sv
module mdio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/mdio_frame_rx.sv
module mdio_frame_rx
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int PHY_W   = 5,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 16,
  localparam int CNT_W  = $clog2(DATA_W),
  localparam int PRE_W  = $clog2(PRE_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdio_i,
  input  logic [PHY_W-1:0]  phy_addr_i,
  output mdio_st_e          state_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [1:0]        op_o,
  output logic              phy_match_o,
  output logic [REG_W-1:0]  reg_addr_o,
  output logic              rd_act_o,
  output logic              tx_load_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o
);

  localparam logic [PRE_W-1:0] PRE_FULL = PRE_W'(PRE_LEN);
  localparam logic [CNT_W-1:0] OP_LAST  = CNT_W'(1);
  localparam logic [CNT_W-1:0] PHY_LAST = CNT_W'(PHY_W - 1);
  localparam logic [CNT_W-1:0] REG_LAST = CNT_W'(REG_W - 1);
  localparam logic [CNT_W-1:0] TA_LAST  = CNT_W'(1);
  localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DATA_W - 1);

  mdio_st_e            st_q,  st_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [PRE_W-1:0]    pre_q, pre_d;
  logic [1:0]          op_q,  op_d;
  logic [PHY_W-1:0]    phy_q, phy_d;
  logic [REG_W-1:0]    reg_q, reg_d;
  logic [DATA_W-1:0]   dat_q, dat_d;
  logic                tail_phase;
  logic                addr_hit;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    pre_d = pre_q;
    op_d  = op_q;
    phy_d = phy_q;
    reg_d = reg_q;
    dat_d = dat_q;
    unique case (st_q)
      ST_PRE: begin
        if (mdio_i) begin
          if (pre_q != PRE_FULL) begin
            pre_d = pre_q + 1'b1;
          end
        end else begin
          if (pre_q == PRE_FULL) begin
            st_d = ST_START;
          end
          pre_d = '0;
        end
      end
      ST_START: begin
        cnt_d = '0;
        st_d  = mdio_i ? ST_OP : ST_PRE;
      end
      ST_OP: begin
        op_d = {op_q[0], mdio_i};
        if (cnt_q == OP_LAST) begin
          st_d  = ST_PHY;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_PHY: begin
        phy_d = {phy_q[PHY_W-2:0], mdio_i};
        if (cnt_q == PHY_LAST) begin
          st_d  = ST_REG;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_REG: begin
        reg_d = {reg_q[REG_W-2:0], mdio_i};
        if (cnt_q == REG_LAST) begin
          st_d  = ST_TA;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_TA: begin
        if (cnt_q == TA_LAST) begin
          st_d  = ST_DATA;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_DATA: begin
        dat_d = {dat_q[DATA_W-2:0], mdio_i};
        if (cnt_q == DAT_LAST) begin
          st_d  = ST_PRE;
          cnt_d = '0;
          pre_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        st_d  = ST_PRE;
        cnt_d = '0;
        pre_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_PRE;
      cnt_q <= '0;
      pre_q <= '0;
      op_q  <= '0;
      phy_q <= '0;
      reg_q <= '0;
      dat_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      pre_q <= pre_d;
      op_q  <= op_d;
      phy_q <= phy_d;
      reg_q <= reg_d;
      dat_q <= dat_d;
    end
  end

  assign tail_phase  = (st_q == ST_TA) || (st_q == ST_DATA);
  assign addr_hit    = (phy_q == phy_addr_i);

  assign state_o     = st_q;
  assign cnt_o       = cnt_q;
  assign op_o        = op_q;
  assign phy_match_o = addr_hit;
  assign reg_addr_o  = reg_q;
  assign rd_act_o    = tail_phase && addr_hit && (op_q == OPC_READ);
  assign tx_load_o   = rd_act_o && (st_q == ST_TA) && (cnt_q == TA_LAST);
  assign wr_en_o     = addr_hit && (op_q == OPC_WRITE) &&
                       (st_q == ST_DATA) && (cnt_q == DAT_LAST);
  assign wr_data_o   = {dat_q[DATA_W-2:0], mdio_i};

endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank #(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 5,
  parameter int DATA_W   = 16,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [REG_W-1:0]    addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W-1:0]   rd_data,
  output logic [NUM_REGS-1:0] wr_hit
);

  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic              addr_ok;

  assign addr_ok = (int'(addr) < NUM_REGS);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign wr_hit[g] = wr_en && (int'(addr) == g);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        regs_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (wr_hit[i]) begin
          regs_q[i] <= wr_data;
        end
      end
    end
  end

  assign rd_data = addr_ok ? regs_q[addr[IDX_W-1:0]] : '1;

endmodule

// File: rtl/mdio_tx.sv
module mdio_tx
  import mdio_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mdio_st_e          state,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              rd_act,
  input  logic              load,
  input  logic [DATA_W-1:0] rd_data,
  output logic              mdio_o,
  output logic              mdio_oe
);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic              oe_d, o_d;
  logic              shift_en;

  assign shift_en = rd_act && (state == ST_DATA);

  always_comb begin
    sh_d = sh_q;
    if (load) begin
      sh_d = rd_data;
    end else if (shift_en) begin
      sh_d = {sh_q[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  always_comb begin
    oe_d = rd_act && (((state == ST_TA) && (cnt == CNT_W'(1))) || (state == ST_DATA));
    o_d  = (state == ST_DATA) ? sh_q[DATA_W-1] : 1'b0;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdio_oe <= 1'b0;
      mdio_o  <= 1'b0;
    end else begin
      mdio_oe <= oe_d;
      mdio_o  <= o_d;
    end
  end

endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int PRE_LEN  = 32,
  parameter int PHY_W    = 5,
  parameter int REG_W    = 5,
  parameter int DATA_W   = 16
) (
  input  logic             mdc,
  input  logic             rst_n,
  input  logic [PHY_W-1:0] phy_addr_i,
  input  logic             mdio_i,
  output logic             mdio_o,
  output logic             mdio_oe
);

  localparam int CNT_W = $clog2(DATA_W);

  logic                rst_s_n;
  mdio_st_e            fr_state;
  logic [CNT_W-1:0]    fr_cnt;
  logic [1:0]          fr_op;
  logic                fr_match;
  logic [REG_W-1:0]    fr_reg;
  logic                fr_rd_act;
  logic                fr_load;
  logic                fr_wr_en;
  logic [DATA_W-1:0]   fr_wr_data;
  logic [DATA_W-1:0]   bank_rd_data;
  logic [NUM_REGS-1:0] bank_wr_hit;

  mdio_rst_sync u_rst (
    .clk        (mdc),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  mdio_frame_rx #(
    .PRE_LEN (PRE_LEN),
    .PHY_W   (PHY_W),
    .REG_W   (REG_W),
    .DATA_W  (DATA_W)
  ) u_rx (
    .clk         (mdc),
    .rst_n       (rst_s_n),
    .mdio_i      (mdio_i),
    .phy_addr_i  (phy_addr_i),
    .state_o     (fr_state),
    .cnt_o       (fr_cnt),
    .op_o        (fr_op),
    .phy_match_o (fr_match),
    .reg_addr_o  (fr_reg),
    .rd_act_o    (fr_rd_act),
    .tx_load_o   (fr_load),
    .wr_en_o     (fr_wr_en),
    .wr_data_o   (fr_wr_data)
  );

  mdio_reg_bank #(
    .NUM_REGS (NUM_REGS),
    .REG_W    (REG_W),
    .DATA_W   (DATA_W)
  ) u_bank (
    .clk     (mdc),
    .rst_n   (rst_s_n),
    .wr_en   (fr_wr_en),
    .addr    (fr_reg),
    .wr_data (fr_wr_data),
    .rd_data (bank_rd_data),
    .wr_hit  (bank_wr_hit)
  );

  mdio_tx #(
    .DATA_W (DATA_W)
  ) u_tx (
    .clk     (mdc),
    .rst_n   (rst_s_n),
    .state   (fr_state),
    .cnt     (fr_cnt),
    .rd_act  (fr_rd_act),
    .load    (fr_load),
    .rd_data (bank_rd_data),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
  );

endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker
  import mdio_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 5,
  parameter int CNT_W    = 4
) (
  input logic                clk,
  input logic                rst_n,
  input mdio_st_e            state,
  input logic [CNT_W-1:0]    cnt,
  input logic [1:0]          op,
  input logic                phy_match,
  input logic [REG_W-1:0]    reg_addr,
  input logic                rd_act,
  input logic                wr_en,
  input logic [NUM_REGS-1:0] wr_hit,
  input logic                mdio_o,
  input logic                mdio_oe
);

  logic tail;
  logic unimpl;

  assign tail   = (state == ST_TA) || (state == ST_DATA);
  assign unimpl = (int'(reg_addr) >= NUM_REGS);

  AST_TA_FIRST_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TA && cnt == CNT_W'(0)) |-> !mdio_oe); // R3

  AST_TA_SECOND_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TA && cnt == CNT_W'(1) && rd_act) |-> (mdio_oe && !mdio_o)); // R3

  AST_HEADER_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (!tail) |-> !mdio_oe); // R8

  AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (tail && !phy_match) |-> (!mdio_oe && !wr_en)); // R2

  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (tail && op == OPC_WRITE) |-> !mdio_oe); // R5

  AST_WRITE_ONE_REG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !unimpl) |-> ($countones(wr_hit) == 1)); // R5

  AST_UNIMPL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && rd_act && unimpl) |-> (mdio_oe && mdio_o)); // R6

  AST_UNIMPL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && unimpl) |-> (wr_hit == '0)); // R7

  AST_BADOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (tail && (op == 2'b00 || op == 2'b11)) |-> (!mdio_oe && !wr_en)); // R10

  AST_DATA_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && rd_act) |-> mdio_oe); // R4

endmodule

bind mdio_mgmt_slave mdio_mgmt_checker #(
  .NUM_REGS (NUM_REGS),
  .REG_W    (REG_W),
  .CNT_W    (CNT_W)
) u_chk (
  .clk       (mdc),
  .rst_n     (rst_n),
  .state     (fr_state),
  .cnt       (fr_cnt),
  .op        (fr_op),
  .phy_match (fr_match),
  .reg_addr  (fr_reg),
  .rd_act    (fr_rd_act),
  .wr_en     (fr_wr_en),
  .wr_hit    (bank_wr_hit),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe)
);

// File: tb/tb_mdio_mgmt_slave.sv
module tb_mdio_mgmt_slave;

  localparam int NREG = 8;
  localparam logic [4:0] MY_PHY = 5'h05;

  logic mdc;
  logic rst_n;
  logic m_oe;
  logic m_drv;
  logic dut_o;
  logic dut_oe;
  logic line;
  logic [4:0] phy_cfg;

  int checks;
  int errors;
  bit done;

  // reference model state
  logic [15:0] model [NREG];

  // per-bit expectation queues
  bit    q_mo  [$];
  bit    q_mv  [$];
  bit    q_eoe [$];
  bit    q_eo  [$];
  string q_req [$];

  assign line = dut_oe ? dut_o : (m_oe ? m_drv : 1'b1);

  mdio_mgmt_slave dut (
    .mdc        (mdc),
    .rst_n      (rst_n),
    .phy_addr_i (phy_cfg),
    .mdio_i     (line),
    .mdio_o     (dut_o),
    .mdio_oe    (dut_oe)
  );

  initial mdc = 1'b0;
  always #10 mdc = ~mdc;

  task automatic put(input bit mo, input bit mv, input bit eoe, input bit eo, input string req);
    q_mo.push_back(mo);
    q_mv.push_back(mv);
    q_eoe.push_back(eoe);
    q_eo.push_back(eo);
    q_req.push_back(req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(1'b0, 1'b0, 1'b0, 1'b0, "R8");
  endtask

  task automatic zero_bit();
    put(1'b1, 1'b0, 1'b0, 1'b0, "R1");
  endtask

  // Build one frame's bits and expectations; update the model as a write would.
  task automatic frame(input int pre, input bit [1:0] op, input bit [4:0] phy,
                       input bit [4:0] ra, input bit [15:0] wd, input string req);
    bit valid, hit, is_rd, is_wr;
    bit [15:0] rd;
    valid = (pre >= 32);
    hit   = valid && (phy == MY_PHY);
    is_rd = (op == 2'b10);
    is_wr = (op == 2'b01);
    rd    = (int'(ra) < NREG) ? model[ra[2:0]] : 16'hFFFF;
    for (int i = 0; i < pre; i++) put(1'b1, 1'b1, 1'b0, 1'b0, req);
    put(1'b1, 1'b0, 1'b0, 1'b0, req);
    put(1'b1, 1'b1, 1'b0, 1'b0, req);
    for (int i = 1; i >= 0; i--) put(1'b1, op[i], 1'b0, 1'b0, req);
    for (int i = 4; i >= 0; i--) put(1'b1, phy[i], 1'b0, 1'b0, req);
    for (int i = 4; i >= 0; i--) put(1'b1, ra[i], 1'b0, 1'b0, req);
    if (is_rd) begin
      put(1'b0, 1'b0, 1'b0, 1'b0, "R3");
      put(1'b0, 1'b0, hit, 1'b0, "R3");
      for (int i = 15; i >= 0; i--) put(1'b0, 1'b0, hit, rd[i], hit ? req : "R2");
    end else begin
      put(1'b1, 1'b1, 1'b0, 1'b0, req);
      put(1'b1, 1'b0, 1'b0, 1'b0, req);
      for (int i = 15; i >= 0; i--) put(1'b1, wd[i], 1'b0, 1'b0, req);
      if (hit && is_wr && int'(ra) < NREG) model[ra[2:0]] = wd;
    end
  endtask

  task automatic rd_frame(input bit [4:0] ra, input string req);
    frame(32, 2'b10, MY_PHY, ra, 16'h0000, req);
  endtask

  task automatic wr_frame(input bit [4:0] ra, input bit [15:0] d, input string req);
    frame(32, 2'b01, MY_PHY, ra, d, req);
  endtask

  task automatic run_queue();
    int n;
    n = 0;
    while (q_mo.size() > 0) begin
      bit mo, mv, eoe, eo;
      string req;
      mo = q_mo.pop_front();
      mv = q_mv.pop_front();
      eoe = q_eoe.pop_front();
      eo = q_eo.pop_front();
      req = q_req.pop_front();
      @(negedge mdc);
      m_oe  = mo;
      m_drv = mv;
      #8;
      checks++;
      if (dut_oe !== eoe || (eoe && dut_o !== eo)) begin
        errors++;
        $display("FAIL %s bit %0d: oe=%b o=%b expected oe=%b o=%b", req, n, dut_oe, dut_o, eoe, eo);
      end
      if (dut_oe === 1'b1 && mo) begin
        checks++;
        errors++;
        $display("FAIL %s bit %0d: line conflict oe=%b expected oe=0", req, n, dut_oe);
      end
      n++;
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run not finished, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    done = 0;
    m_oe = 1'b0;
    m_drv = 1'b0;
    phy_cfg = MY_PHY;
    rst_n = 1'b0;
    for (int i = 0; i < NREG; i++) model[i] = 16'h0000;
    repeat (3) @(negedge mdc);
    #8;
    checks++; // R11 output tri-stated in reset
    if (dut_oe !== 1'b0) begin
      errors++;
      $display("FAIL R11: oe=%b expected 0", dut_oe);
    end
    @(negedge mdc);
    rst_n = 1'b1;

    idle(4);
    rd_frame(5'd3, "R11");                   // reset value
    wr_frame(5'd3, 16'hA5C3, "R5");
    rd_frame(5'd3, "R4");
    idle(2);
    // back-to-back, no idle bit between frames
    wr_frame(5'd0, 16'h1234, "R9");
    rd_frame(5'd0, "R9");
    wr_frame(5'd7, 16'h8001, "R9");
    rd_frame(5'd7, "R4");
    // unimplemented addresses
    rd_frame(5'd20, "R6");
    rd_frame(5'd31, "R6");
    wr_frame(5'd20, 16'hBEEF, "R7");
    wr_frame(5'd8, 16'h5555, "R7");
    for (int r = 0; r < NREG; r++) rd_frame(5'(r), "R7");
    // other PHY address
    frame(32, 2'b10, 5'h06, 5'd3, 16'h0000, "R2");
    frame(32, 2'b01, 5'h04, 5'd3, 16'hFFFF, "R2");
    rd_frame(5'd3, "R2");
    // short preamble, preceded by a forced zero
    zero_bit();
    frame(31, 2'b01, MY_PHY, 5'd5, 16'hF00D, "R1");
    zero_bit();
    frame(31, 2'b10, MY_PHY, 5'd0, 16'h0000, "R1");
    frame(40, 2'b01, MY_PHY, 5'd6, 16'h0F0F, "R1");
    rd_frame(5'd5, "R1");
    rd_frame(5'd6, "R1");
    // unused opcodes
    frame(32, 2'b11, MY_PHY, 5'd2, 16'hCAFE, "R10");
    frame(32, 2'b00, MY_PHY, 5'd2, 16'h7777, "R10");
    rd_frame(5'd2, "R10");
    idle(6);                                 // R8 idle tri-state

    run_queue();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule